// File: doc/BRIEF.md
# Multiprocessor-bit UART transmitter

This block is the transmit half of an asynchronous serial link on which several nodes share one line. Each frame carries one extra flag bit after the data byte. A 1 marks an address frame and a 0 marks a data frame, so receiving nodes can skip data that is not meant for them. The host gives the byte and the flag together in a single write strobe. The block keeps that pair in a one-deep data register. It reports two status flags: "register empty" and "transmission done". It also drives a transmit-empty request output, which an interrupt controller or a transfer engine can use.

Bit timing comes from a baud-tick input, and each bit lasts 16 ticks. When transmit enable rises, the block first holds the line high for one full frame time and only then sends data. When enable is low, the line is handed to a port fallback (a direction bit and a data bit). Software can therefore hold the line low as a break once the last frame has finished.

Top module: `mpb_uart_tx`

## Requirements
- R1: A frame is a start bit (0), then the 8 data bits with the least significant bit first, then the multiprocessor bit, then a stop bit (1). Each bit lasts exactly 16 baud ticks, and only baud ticks advance the bit timing.
- R2: The multiprocessor bit of a frame equals the `wr_mpb` value given in the same write as the frame's byte.
- R3: After `tx_en` goes from 0 to 1, the line stays at 1 for 176 baud ticks (one frame time) before the first start bit, even if a byte is already waiting.
- R4: A write is accepted only while `tdr_empty` is 1, and acceptance clears `tdr_empty` to 0. A write while `tdr_empty` is 0 is ignored and its byte is never sent.
- R5: When a waiting byte is taken into the shift register, `tdr_empty` returns to 1. This happens at the end of a stop bit or of the initial idle frame, or at once if the line is idle. A byte taken at the end of a stop bit starts its start bit with no gap.
- R6: `tx_done` is 1 after reset. It is cleared by an accepted write. It is set when a frame time (including the initial idle frame) ends with no byte waiting.
- R7: While enabled and not in a frame, `txd` is 1.
- R8: While the transmitter is disabled, `txd` equals `port_dat` when `port_dir` is 1, and is 1 otherwise. Disabling aborts any frame in progress.
- R9: `txe_req` is 1 exactly when the transmitter is enabled and `tdr_empty` is 1. After reset it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_en | input | 1 | Transmit enable |
| wr_valid | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Byte to send |
| wr_mpb | input | 1 | Multiprocessor bit for this byte (1 = address, 0 = data) |
| port_dir | input | 1 | Port fallback direction, 1 = drive |
| port_dat | input | 1 | Port fallback data level |
| txd | output | 1 | Serial line |
| tdr_empty | output | 1 | Data register can take a byte |
| tx_done | output | 1 | Last frame has left the line and nothing waits |
| txe_req | output | 1 | Transmit-empty request |

## Verification
A wrong frame shift register or bit counter shows up on `txd` within one bit time, 16 ticks: a misplaced bit, a missing stop, or a frame that runs one bit too long. A wrong empty or done flag shows up at the status ports on the cycle after a write or a load. Bytes that are lost or sent twice appear only one frame later, as a missing or extra frame on the line. A preamble-length error appears as a start bit that comes too early or too late relative to the rise of enable.

// File: rtl/mpbtx_pkg.sv
package mpbtx_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_PRE  = 2'd1,
    ST_IDLE = 2'd2,
    ST_SEND = 2'd3
  } tx_state_e;
endpackage

// File: rtl/mpbtx_bitclk.sv
module mpbtx_bitclk #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic baud_tick,
  output logic bit_end
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  logic [CW-1:0] cnt;

  assign bit_end = run && baud_tick && (cnt == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run)          cnt <= '0;
    else if (bit_end)       cnt <= '0;
    else if (baud_tick)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mpbtx_hold.sv
module mpbtx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_mpb,
  input  logic          take,
  input  logic          set_done,
  output logic [DW-1:0] hold_data,
  output logic          hold_mpb,
  output logic          empty,
  output logic          done,
  output logic          accept
);
  assign accept = wr_valid && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_mpb  <= 1'b0;
      empty     <= 1'b1;
      done      <= 1'b1;
    end else begin
      if (accept) begin
        hold_data <= wr_data;
        hold_mpb  <= wr_mpb;
        empty     <= 1'b0;
      end else if (take) begin
        empty     <= 1'b1;
      end
      if (accept)        done <= 1'b0;
      else if (set_done) done <= 1'b1;
    end
  end
endmodule

// File: rtl/mpbtx_shift.sv
module mpbtx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_data,
  input  logic          load_fill,
  input  logic          bit_end,
  input  logic [DW-1:0] data_in,
  input  logic          mpb_in,
  output logic          line,
  output logic          last_bit
);
  localparam int FW = DW + 3;
  localparam int IW = $clog2(FW);

  function automatic logic [FW-1:0] frame_of(input logic [DW-1:0] d, input logic m);
    return {1'b1, m, d, 1'b0};
  endfunction

  logic [FW-1:0] frame;
  logic [IW-1:0] idx;

  assign line     = frame[0];
  assign last_bit = (idx == IW'(FW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '1;
      idx   <= '0;
    end else if (load_data) begin
      frame <= frame_of(data_in, mpb_in);
      idx   <= '0;
    end else if (load_fill) begin
      frame <= '1;
      idx   <= '0;
    end else if (bit_end) begin
      frame <= {1'b1, frame[FW-1:1]};
      if (!last_bit) idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/mpb_uart_tx.sv
module mpb_uart_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mpb,
  input  logic              port_dir,
  input  logic              port_dat,
  output logic              txd,
  output logic              tdr_empty,
  output logic              tx_done,
  output logic              txe_req
);
  import mpbtx_pkg::*;

  tx_state_e state, state_nxt;
  logic bit_end, line, last_bit, frame_end, run;
  logic load_ev, fill_ev, set_done, wr_accept;
  logic sending, quiet, off;
  logic [DATA_W-1:0] hold_data;
  logic hold_mpb;

  assign run       = (state == ST_PRE) || (state == ST_SEND);
  assign frame_end = run && bit_end && last_bit;
  assign sending   = (state == ST_SEND);
  assign quiet     = (state == ST_IDLE);
  assign off       = (state == ST_OFF);

  always_comb begin
    state_nxt = state;
    load_ev   = 1'b0;
    fill_ev   = 1'b0;
    set_done  = 1'b0;
    unique case (state)
      ST_OFF: if (tx_en) begin
        state_nxt = ST_PRE;
        fill_ev   = 1'b1;
      end
      ST_PRE, ST_SEND: begin
        if (!tx_en) state_nxt = ST_OFF;
        else if (frame_end) begin
          if (!tdr_empty) begin
            load_ev   = 1'b1;
            state_nxt = ST_SEND;
          end else begin
            set_done  = 1'b1;
            state_nxt = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (!tx_en) state_nxt = ST_OFF;
        else if (!tdr_empty) begin
          load_ev   = 1'b1;
          state_nxt = ST_SEND;
        end
      end
      default: state_nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= state_nxt;
  end

  mpbtx_bitclk #(.OVS(OVS)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(run), .baud_tick(baud_tick), .bit_end(bit_end)
  );

  mpbtx_hold #(.DW(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_mpb(wr_mpb),
    .take(load_ev), .set_done(set_done), .hold_data(hold_data), .hold_mpb(hold_mpb),
    .empty(tdr_empty), .done(tx_done), .accept(wr_accept)
  );

  mpbtx_shift #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_data(load_ev), .load_fill(fill_ev), .bit_end(bit_end),
    .data_in(hold_data), .mpb_in(hold_mpb), .line(line), .last_bit(last_bit)
  );

  assign txd     = off ? (port_dir ? port_dat : 1'b1) : (run ? line : 1'b1);
  assign txe_req = tdr_empty && !off;
endmodule

// File: rtl/mpbtx_checker.sv
module mpbtx_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic port_dir,
  input logic port_dat,
  input logic txd,
  input logic tdr_empty,
  input logic tx_done,
  input logic txe_req,
  input logic load_ev,
  input logic wr_accept,
  input logic sending,
  input logic quiet,
  input logic off
);
  a_r5_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> tdr_empty);
  a_r4_accept_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !tdr_empty);
  a_r6_write_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !tx_done);
  a_r6_done_not_sending: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !sending);
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> txd);
  a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (off && port_dir && !port_dat) |-> !txd);
  a_r1_start_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && tx_en) |=> !txd);
  a_r9_request_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && tx_en) |=> txe_req);
  a_r9_no_request_off: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> !txe_req);
endmodule

bind mpb_uart_tx mpbtx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .port_dir(port_dir), .port_dat(port_dat),
  .txd(txd), .tdr_empty(tdr_empty), .tx_done(tx_done), .txe_req(txe_req),
  .load_ev(load_ev), .wr_accept(wr_accept), .sending(sending), .quiet(quiet), .off(off)
);

// File: tb/mpb_uart_tx_test.sv
module mpb_uart_tx_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic tx_en = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_mpb = 1'b0;
  logic port_dir = 1'b0;
  logic port_dat = 1'b1;
  logic txd, tdr_empty, tx_done, txe_req;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) baud_tick <= ~baud_tick;

  mpb_uart_tx uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_mpb(wr_mpb),
    .port_dir(port_dir), .port_dat(port_dat), .txd(txd),
    .tdr_empty(tdr_empty), .tx_done(tx_done), .txe_req(txe_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (baud_tick) k++;
    end
    @(negedge clk);
  endtask

  function automatic logic [10:0] expect_frame(input logic [7:0] d, input logic m);
    logic [10:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    f[9]  = m;
    f[10] = 1'b1;
    return f;
  endfunction

  // aligned=1: previous call ended mid stop bit; next start begins 8 ticks later
  task automatic rx_frame(input bit aligned, output logic [10:0] bits, output int lead);
    lead = 0;
    if (aligned) wait_ticks(16);
    else begin
      while (txd === 1'b1 && lead < 400) begin
        wait_ticks(1);
        lead++;
      end
      wait_ticks(8);
    end
    bits[0] = txd;
    for (int i = 1; i < 11; i++) begin
      wait_ticks(16);
      bits[i] = txd;
    end
  endtask

  task automatic host_write(input logic [7:0] d, input logic m);
    wr_valid = 1'b1; wr_data = d; wr_mpb = m;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R6 empty after reset", tdr_empty, 1);
    chk("R6 done after reset", tx_done, 1);
    chk("R9 request after reset", txe_req, 0);
    chk("R8 line released after reset", txd, 1);
  endtask

  task automatic t_break;
    port_dir = 1'b1; port_dat = 1'b0; @(negedge clk);
    chk("R8 break holds line low", txd, 0);
    port_dat = 1'b1; @(negedge clk);
    chk("R8 port drives high", txd, 1);
    port_dir = 1'b0; port_dat = 1'b0; @(negedge clk);
    chk("R8 undriven port reads high", txd, 1);
    port_dat = 1'b1;
  endtask

  task automatic t_preamble;
    logic [10:0] bits; int lead;
    host_write(8'hA5, 1'b1);
    chk("R4 write accepted while disabled", tdr_empty, 0);
    chk("R6 write clears done", tx_done, 0);
    chk("R9 no request while disabled", txe_req, 0);
    tx_en = 1'b1;
    rx_frame(1'b0, bits, lead);
    chk("R3 idle frame length lower", lead >= 176, 1);
    chk("R3 idle frame length upper", lead <= 177, 1);
    chk("R1 R2 address frame", bits, expect_frame(8'hA5, 1'b1));
    chk("R5 empty after load", tdr_empty, 1);
    chk("R9 request while enabled and empty", txe_req, 1);
    chk("R6 done low during frame", tx_done, 0);
    wait_ticks(10);
    chk("R6 done after last stop", tx_done, 1);
    chk("R7 line idles high", txd, 1);
  endtask

  task automatic t_back_to_back;
    logic [10:0] a, b; int lead;
    host_write(8'h3C, 1'b0);
    @(negedge clk);
    chk("R5 idle load frees register", tdr_empty, 1);
    host_write(8'hC3, 1'b1);
    chk("R4 second write accepted", tdr_empty, 0);
    host_write(8'h77, 1'b0);
    chk("R4 write while full keeps full", tdr_empty, 0);
    rx_frame(1'b0, a, lead);
    chk("R1 R2 data frame", a, expect_frame(8'h3C, 1'b0));
    chk("R6 done low with byte waiting", tx_done, 0);
    rx_frame(1'b1, b, lead);
    chk("R5 R2 back-to-back frame", b, expect_frame(8'hC3, 1'b1));
    wait_ticks(24);
    chk("R4 ignored byte never sent", txd, 1);
    chk("R6 done after final frame", tx_done, 1);
    chk("R4 register empty at end", tdr_empty, 1);
  endtask

  task automatic t_abort;
    host_write(8'h00, 1'b0);
    wait_ticks(40);
    port_dir = 1'b1; port_dat = 1'b0;
    tx_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 disable mid-frame hands line to port", txd, 0);
    chk("R9 request drops when disabled", txe_req, 0);
    port_dat = 1'b1; @(negedge clk);
    chk("R8 aborted frame not resumed", txd, 1);
    port_dir = 1'b0;
    tx_en = 1'b1;
    wait_ticks(100);
    chk("R3 R7 line high during idle frame", txd, 1);
    wait_ticks(90);
    chk("R6 done after idle frame with nothing waiting", tx_done, 1);
    chk("R7 line high after idle frame", txd, 1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_break();
    t_preamble();
    t_back_to_back();
    t_abort();
    finish_run();
  end
endmodule